// File: doc/BRIEF.md
# Manchester response transmitter

This block sends a short reply frame on a single serial line after a receive strobe has marked a valid incoming call. When the receive strobe rises, the block opens a request window and starts an absolute timer. If an active-high send request arrives inside that window, the block captures the parallel response word and asserts busy. It then holds the word until a fixed lead time after the strobe, and that lead time depends on the mode. At that point it shifts out the frame as active-low Manchester-II code.

The start of the reply is pinned to the strobe, not to the request, so the reply delay seen on the line is the same wherever the request falls inside the window. The lead is 11.75 µs in synchronous mode and 12.25 µs in asynchronous mode. The mode is sampled on the strobe edge. All timing is given in clock cycles through parameters. The defaults assume a 4 ns clock: 750 cycles per half bit, a 1500-cycle window, and leads of 2938 and 3062 cycles.

Top module: `mresp_tx`

## Requirements
- R1: During and after reset, and whenever no frame is being sent, `line_n` is high and `busy` is low.
- R2: A frame has seven bits, sent in this order: a start bit of 0, the four bits of `tx_word` LSB first, a parity bit that makes the number of ones in data plus parity even, and an end bit of 1.
- R3: Each bit lasts two halves of `HALF_CYC` cycles, with a level change at mid-bit. A 0 is sent low then high, and a 1 is sent high then low.
- R4: With `async_mode` low at the strobe edge, the first low level of `line_n` appears at the clock edge `LEAD_SYNC_CYC` edges after the edge that first samples `rx_strobe` high.
- R5: With `async_mode` high at the strobe edge, that first low level appears `LEAD_ASYNC_CYC` edges after the strobe edge.
- R6: A request is accepted only if it is sampled 1 to `WINDOW_CYC` edges after the strobe edge. A request sampled at the strobe edge itself, or later than the window, produces no frame.
- R7: `busy` rises at the edge after an accepted request and falls at the edge where the end bit completes. Strobes and requests sampled while busy are ignored, and the frame being sent is not changed by them.
- R8: A new strobe edge while the window is open restarts the window and the timer. A request sampled at that same edge is dropped.
- R9: Changes of `async_mode` after the strobe edge do not affect the lead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| async_mode | input | 1 | 1 selects the long (asynchronous) lead, sampled at the strobe edge |
| rx_strobe | input | 1 | Receive strobe, the rising edge starts the window and timer |
| send_req | input | 1 | Active-high send request |
| tx_word | input | DATA_W | Response data captured on accept |
| busy | output | 1 | High from accept until the end bit completes |
| line_n | output | 1 | Active-low Manchester serial output, idles high |

## Verification
Two of the block's functions can fall in the same cycle: a window restart from a fresh strobe edge, and the acceptance of a request. The bench provokes this by raising `rx_strobe` and `send_req` together while a window is already open, with a distinctive word on `tx_word`. It judges the result by the line. No frame may appear at the lead time of either strobe for that word. A later request must then produce its frame at exactly the lead counted from the second strobe edge. A request sent in the cycle after a frame ends would show the same kind of conflict. Here the bench instead places a strobe and a request in the middle of a transmission and confirms that the frame and its end time stay unchanged.

// File: rtl/mresp_pkg.sv
package mresp_pkg;

  typedef enum logic [1:0] {
    SCH_IDLE  = 2'd0,
    SCH_OPEN  = 2'd1,
    SCH_ARMED = 2'd2
  } sch_state_e;

endpackage

// File: rtl/mresp_sched.sv
module mresp_sched
  import mresp_pkg::*;
#(
  parameter int DATA_W         = 4,
  parameter int WINDOW_CYC     = 1500,
  parameter int LEAD_SYNC_CYC  = 2938,
  parameter int LEAD_ASYNC_CYC = 3062,
  localparam int FRAME_W       = DATA_W + 3,
  localparam int MAX_LEAD      = (LEAD_ASYNC_CYC > LEAD_SYNC_CYC) ? LEAD_ASYNC_CYC : LEAD_SYNC_CYC,
  localparam int TW            = $clog2(MAX_LEAD + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_strobe,
  input  logic               async_mode,
  input  logic               send_req,
  input  logic [DATA_W-1:0]  tx_word,
  input  logic               ser_active,
  output logic               start_o,
  output logic               armed_o,
  output logic [FRAME_W-1:0] frame_o
);

  localparam logic [TW-1:0] WIN_T   = TW'(WINDOW_CYC);
  localparam logic [TW-1:0] SYNC_T  = TW'(LEAD_SYNC_CYC);
  localparam logic [TW-1:0] ASYNC_T = TW'(LEAD_ASYNC_CYC);
  localparam logic [TW-1:0] ONE_T   = TW'(1);

  sch_state_e         state_q, state_d;
  logic [TW-1:0]      tmr_q, tmr_d;
  logic               mode_q, mode_d;
  logic               strobe_q;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               rise;
  logic [TW-1:0]      lead;

  assign rise = rx_strobe & ~strobe_q;
  assign lead = mode_q ? ASYNC_T : SYNC_T;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    mode_d  = mode_q;
    frame_d = frame_q;
    start_o = 1'b0;
    unique case (state_q)
      SCH_IDLE: begin
        if (rise && !ser_active) begin
          state_d = SCH_OPEN;
          tmr_d   = ONE_T;
          mode_d  = async_mode;
        end
      end
      SCH_OPEN: begin
        if (rise) begin
          tmr_d  = ONE_T;
          mode_d = async_mode;
        end else if (send_req) begin
          state_d = SCH_ARMED;
          tmr_d   = tmr_q + ONE_T;
          frame_d = {1'b1, ^tx_word, tx_word, 1'b0};
        end else if (tmr_q == WIN_T) begin
          state_d = SCH_IDLE;
        end else begin
          tmr_d = tmr_q + ONE_T;
        end
      end
      SCH_ARMED: begin
        if (tmr_q == lead) begin
          state_d = SCH_IDLE;
          start_o = 1'b1;
        end else begin
          tmr_d = tmr_q + ONE_T;
        end
      end
      default: state_d = SCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SCH_IDLE;
      tmr_q    <= '0;
      mode_q   <= 1'b0;
      strobe_q <= 1'b0;
      frame_q  <= '0;
    end else begin
      state_q  <= state_d;
      tmr_q    <= tmr_d;
      mode_q   <= mode_d;
      strobe_q <= rx_strobe;
      frame_q  <= frame_d;
    end
  end

  assign armed_o = (state_q == SCH_ARMED);
  assign frame_o = frame_q;

  p_window_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCH_OPEN) |-> (tmr_q >= ONE_T && tmr_q <= WIN_T));

  p_lead_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCH_ARMED) |-> (tmr_q <= lead));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCH_ARMED) |=> (state_q != SCH_ARMED) || $stable(mode_q));

endmodule

// File: rtl/mresp_serializer.sv
module mresp_serializer #(
  parameter int FRAME_W  = 7,
  parameter int HALF_CYC = 750,
  localparam int HW      = $clog2(HALF_CYC + 1),
  localparam int IW      = $clog2(2 * FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               active_o,
  output logic               line_n
);

  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYC - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(2 * FRAME_W - 1);

  logic          active_q, active_d;
  logic [HW-1:0] hc_q, hc_d;
  logic [IW-1:0] hi_q, hi_d;
  logic          line_q, line_d;
  logic          hc_en;

  function automatic logic half_level(input logic [FRAME_W-1:0] fr, input logic [IW-1:0] idx);
    return fr[idx >> 1] ^ idx[0];
  endfunction

  assign hc_en = active_q;

  always_comb begin
    active_d = active_q;
    hc_d     = hc_q;
    hi_d     = hi_q;
    line_d   = line_q;
    if (start_i && !active_q) begin
      active_d = 1'b1;
      hc_d     = '0;
      hi_d     = '0;
      line_d   = half_level(frame_i, '0);
    end else if (hc_en) begin
      if (hc_q == HALF_LAST) begin
        hc_d = '0;
        if (hi_q == IDX_LAST) begin
          active_d = 1'b0;
          hi_d     = '0;
          line_d   = 1'b1;
        end else begin
          hi_d   = hi_q + IW'(1);
          line_d = half_level(frame_i, hi_q + IW'(1));
        end
      end else begin
        hc_d = hc_q + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hc_q     <= '0;
      hi_q     <= '0;
      line_q   <= 1'b1;
    end else begin
      active_q <= active_d;
      hc_q     <= hc_d;
      hi_q     <= hi_d;
      line_q   <= line_d;
    end
  end

  assign active_o = active_q;
  assign line_n   = line_q;

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> line_q);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> !line_q);

  p_mid_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && hc_q == HALF_LAST && !hi_q[0]) |=> (line_q != $past(line_q)));

  p_hold_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && hc_q != HALF_LAST) |=> $stable(line_q));

  p_frame_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> $stable(frame_i));

endmodule

// File: rtl/mresp_tx.sv
module mresp_tx #(
  parameter int DATA_W         = 4,
  parameter int HALF_CYC       = 750,
  parameter int WINDOW_CYC     = 1500,
  parameter int LEAD_SYNC_CYC  = 2938,
  parameter int LEAD_ASYNC_CYC = 3062
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              async_mode,
  input  logic              rx_strobe,
  input  logic              send_req,
  input  logic [DATA_W-1:0] tx_word,
  output logic              busy,
  output logic              line_n
);

  localparam int FRAME_W = DATA_W + 3;

  logic               start;
  logic               armed;
  logic               ser_active;
  logic [FRAME_W-1:0] frame;

  mresp_sched #(
    .DATA_W        (DATA_W),
    .WINDOW_CYC    (WINDOW_CYC),
    .LEAD_SYNC_CYC (LEAD_SYNC_CYC),
    .LEAD_ASYNC_CYC(LEAD_ASYNC_CYC)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_strobe (rx_strobe),
    .async_mode(async_mode),
    .send_req  (send_req),
    .tx_word   (tx_word),
    .ser_active(ser_active),
    .start_o   (start),
    .armed_o   (armed),
    .frame_o   (frame)
  );

  mresp_serializer #(
    .FRAME_W (FRAME_W),
    .HALF_CYC(HALF_CYC)
  ) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .frame_i (frame),
    .active_o(ser_active),
    .line_n  (line_n)
  );

  assign busy = armed | ser_active;

  p_phase_mutex_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && ser_active));

  p_end_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> line_n);

endmodule

// File: tb/mresp_tx_bench.sv
module mresp_tx_bench;

  localparam int H     = 5;
  localparam int WIN   = 12;
  localparam int LSYNC = 30;
  localparam int LASYN = 37;
  localparam int NHALF = 14;

  logic       clk;
  logic       rst_n;
  logic       async_mode;
  logic       rx_strobe;
  logic       send_req;
  logic [3:0] tx_word;
  logic       busy;
  logic       line_n;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit run_mon = 0;
  bit done = 0;

  typedef struct {
    int         t0;
    int         lead;
    logic [6:0] fr;
  } item_t;
  item_t exp_q[$];

  mresp_tx #(
    .DATA_W(4), .HALF_CYC(H), .WINDOW_CYC(WIN),
    .LEAD_SYNC_CYC(LSYNC), .LEAD_ASYNC_CYC(LASYN)
  ) u_mresp_tx (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .rx_strobe(rx_strobe),
    .send_req(send_req), .tx_word(tx_word), .busy(busy), .line_n(line_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, expv);
    end
  endtask

  function automatic logic [6:0] mk_frame(input logic [3:0] w);
    return {1'b1, ^w, w, 1'b0};
  endfunction

  function automatic logic exp_lvl(input logic [6:0] fr, input int h);
    return fr[h / 2] ^ logic'(h % 2);
  endfunction

  // monitor: pops expected frames and compares the line cycle by cycle
  always @(negedge clk) begin
    if (run_mon) begin
      if (exp_q.size() == 0) begin
        chk(line_n == 1'b1, "R1 R6 R7 idle line", int'(line_n), 1);
        chk(busy == 1'b0, "R1 R6 R7 idle busy", int'(busy), 0);
      end else begin
        int rel;
        rel = cyc - exp_q[0].t0 - exp_q[0].lead;
        if (rel >= 0 && rel < NHALF * H) begin
          logic e;
          e = exp_lvl(exp_q[0].fr, rel / H);
          chk(line_n == e, "R2 R3 R4 R5 frame level", int'(line_n), int'(e));
          chk(busy == 1'b1, "R7 busy during frame", int'(busy), 1);
        end else if (rel == NHALF * H) begin
          chk(line_n == 1'b1, "R7 line after end bit", int'(line_n), 1);
          chk(busy == 1'b0, "R7 busy after end bit", int'(busy), 0);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  task automatic strobe_edge(input logic mode, output int t0);
    @(negedge clk);
    rx_strobe  = 1'b1;
    async_mode = mode;
    t0 = cyc + 1;
    @(negedge clk);
    rx_strobe = 1'b0;
  endtask

  task automatic req_at(input int edge_no, input logic [3:0] w, input int hold);
    while (cyc < edge_no - 1) @(negedge clk);
    send_req = 1'b1;
    tx_word  = w;
    repeat (hold) @(negedge clk);
    send_req = 1'b0;
    tx_word  = 4'h0;
  endtask

  task automatic push_exp(input int t0, input logic mode, input logic [3:0] w);
    item_t it;
    it.t0 = t0;
    it.lead = mode ? LASYN : LSYNC;
    it.fr = mk_frame(w);
    exp_q.push_back(it);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int t0;
    int t1;
    rst_n = 1'b0;
    async_mode = 1'b0;
    rx_strobe = 1'b0;
    send_req = 1'b0;
    tx_word = 4'h0;
    repeat (3) @(negedge clk);
    chk(line_n == 1'b1, "R1 reset line", int'(line_n), 1);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_mon = 1;

    // R2 R4: synchronous lead, request early in the window
    strobe_edge(1'b0, t0);
    push_exp(t0, 1'b0, 4'b1011);
    req_at(t0 + 3, 4'b1011, 2);
    wait_idle();

    // R5 R9: asynchronous lead, mode dropped right after the strobe
    strobe_edge(1'b1, t0);
    async_mode = 1'b0;
    push_exp(t0, 1'b1, 4'b0110);
    req_at(t0 + 5, 4'b0110, 2);
    wait_idle();

    // R6: request on the last window edge is accepted
    strobe_edge(1'b0, t0);
    push_exp(t0, 1'b0, 4'b0001);
    req_at(t0 + WIN, 4'b0001, 1);
    wait_idle();

    // R6: request one edge past the window is ignored
    strobe_edge(1'b0, t0);
    req_at(t0 + WIN + 1, 4'b1010, 2);
    while (cyc < t0 + LASYN + NHALF * H + 4) @(negedge clk);
    chk(line_n == 1'b1, "R6 late request line", int'(line_n), 1);
    chk(busy == 1'b0, "R6 late request busy", int'(busy), 0);

    // R6: request sampled at the strobe edge itself is ignored
    @(negedge clk);
    rx_strobe = 1'b1;
    send_req = 1'b1;
    tx_word = 4'b0101;
    t0 = cyc + 1;
    @(negedge clk);
    rx_strobe = 1'b0;
    send_req = 1'b0;
    while (cyc < t0 + LASYN + NHALF * H + 4) @(negedge clk);
    chk(line_n == 1'b1, "R6 same-edge request line", int'(line_n), 1);

    // R7: strobe and request during a transmission are ignored
    strobe_edge(1'b0, t0);
    push_exp(t0, 1'b0, 4'b1100);
    req_at(t0 + 2, 4'b1100, 1);
    while (cyc < t0 + LSYNC + 20) @(negedge clk);
    rx_strobe = 1'b1;
    send_req = 1'b1;
    tx_word = 4'b0011;
    repeat (3) @(negedge clk);
    rx_strobe = 1'b0;
    send_req = 1'b0;
    wait_idle();
    repeat (LASYN + 10) @(negedge clk);
    chk(line_n == 1'b1, "R7 no second frame", int'(line_n), 1);

    // R8: restart of the window beats a request in the same edge
    strobe_edge(1'b1, t0);
    while (cyc < t0 + 3) @(negedge clk);
    rx_strobe = 1'b1;
    async_mode = 1'b0;
    send_req = 1'b1;
    tx_word = 4'b1111;
    t1 = cyc + 1;
    @(negedge clk);
    rx_strobe = 1'b0;
    send_req = 1'b0;
    push_exp(t1, 1'b0, 4'b1000);
    req_at(t1 + 6, 4'b1000, 1);
    wait_idle();
    chk(t1 > t0, "R8 restart ordering", t1, t0 + 4);

    // R2: all-zero and all-one data words, both modes
    strobe_edge(1'b0, t0);
    push_exp(t0, 1'b0, 4'b0000);
    req_at(t0 + 1, 4'b0000, 1);
    wait_idle();
    strobe_edge(1'b1, t0);
    push_exp(t0, 1'b1, 4'b1111);
    req_at(t0 + 7, 4'b1111, 1);
    wait_idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule